// File: doc/BRIEF.md
# Debug Access Transaction Sequencer

This host-side controller turns register-level debug requests into the scan operations a JTAG bit engine performs. A request either names a debug-port register through a three-bit selector or gives a 32-bit access-port address. Each request is expanded into a fixed order of 4-bit instruction loads and 35-bit data shifts. Every read is split into a posted access followed by a fetch of the read buffer. The block keeps a cached copy of the bank/port select value. It issues a select write only when an access-port request moves to another bank or port.

The JTAG engine is reached through a request/acknowledge pair. The sequencer holds `scan_req` with a stable `scan_ir` flag and `scan_out` word until the engine pulses `scan_ack`. The engine returns the captured data-register word on `scan_in` in the same cycle as `scan_ack`. Two parameters set the idle gaps. `SCAN_GAP` cycles follow every access scan, and `WRITE_GAP` further cycles follow an access-port write. Results come back on `rdata` with a one-cycle `done` strobe. On an illegal request, `err` is raised together with `done`.

The controller has nine states:
- `S_IDLE` accepts a request. It moves to `S_DONE` when the request is illegal, to `S_SEL_IR` when a select write is needed, and to `S_ACC_IR` otherwise.
- `S_SEL_IR` moves to `S_SEL_DR` on acknowledge.
- `S_SEL_DR` moves to `S_GAP` and then returns to `S_ACC_IR`.
- `S_ACC_IR` moves to `S_ACC_DR`.
- `S_ACC_DR` moves to `S_DONE` directly after an identification read. Otherwise it moves to `S_GAP`, which then continues to `S_RB_IR` (access-port read), `S_RB_DR` (debug-port posted read) or `S_DONE`.
- `S_RB_IR` moves to `S_RB_DR`.
- `S_RB_DR` moves to `S_GAP` and then to `S_DONE`.
- `S_GAP` counts down its load and then jumps to the stored follow-on state.
- `S_DONE` returns to `S_IDLE`.

Top module: `dbgacc_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `scan_req` are low and the cached select value is zero. An access-port request whose masked address is zero therefore needs no select write until the cache changes.
- R2: An instruction load puts its code in `scan_out[3:0]` with all upper bits zero. The codes are 1010 for debug-port register access, 1011 for access-port access, 1110 for identification read and 1000 for abort write.
- R3: An access data word is `{data[31:0], A[3:2], rnw}`, with rnw=1 for a read. Read scans carry all-zero data.
- R4: `req_reg` encodes 0=identification (read only), 1=abort (write only), 2=control/status, 3=select, 4=read buffer. Codes 5 to 7 are illegal. The A[3:2] values are 0 for identification and abort, 1 for control/status, 2 for select and 3 for read buffer.
- R5: An illegal request raises `err` and `done` together in the cycle after acceptance and issues no scan. Illegal requests are a write to identification or read buffer, a read of abort, and any undefined selector.
- R6: A debug-port read of control/status or select scans 1010, then the posted read, then a read-buffer read (A=3, rnw=1). `rdata` is `scan_in[34:3]` of the last scan. A read-buffer read uses one data scan. An identification read scans 1110 and then 35 zero bits, and returns `scan_in[31:0]`.
- R7: Before an access-port access, the select value is `req_addr & 0xFF0000F0`. When it differs from the cache, code 1010 and a select write (A=2, rnw=0, data = select value) are issued and the cache is updated. A debug-port write to select also loads the cache with the masked write data.
- R8: An access-port access scans 1011, then the access word with A taken from `req_addr[3:2]`. A read then scans 1010 and a read-buffer read, and returns `scan_in[34:3]` of that last scan.
- R9: Every access data scan, including select writes and read-buffer fetches, is followed by `SCAN_GAP` idle cycles. An access-port write adds `WRITE_GAP` more cycles. No gap follows instruction loads or the identification data scan.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. Requests presented while busy are ignored.
- R11: `scan_req`, `scan_ir` and `scan_out` stay unchanged until the cycle in which `scan_ack` is high.
- R12: `done` lasts one cycle. `rdata` changes only for successful reads and holds its value across writes and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, taken when idle |
| req_ap | input | 1 | 1 = access-port request, 0 = debug-port register |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 3 | Debug-port register selector |
| req_addr | input | 32 | Access-port address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Request rejected, valid with done |
| rdata | output | 32 | Read result |
| scan_req | output | 1 | Scan operation requested |
| scan_ir | output | 1 | 1 = instruction load, 0 = data shift |
| scan_out | output | 35 | Instruction code or data word to shift in |
| scan_ack | input | 1 | Engine completed the scan |
| scan_in | input | 35 | Data word shifted out, valid with scan_ack |

## Verification
The hardest situation to reach is a select-cache decision that depends on history. Whether a select write appears depends on every earlier access-port request and on any direct debug-port write of select, not on the current request alone. The stimulus therefore runs a chained sequence: a first bank change, then a repeat within the same bank whose address differs only in masked-off bits, then a change in the port-nibble bits, then a direct select write that resets the cache to zero, then an access to bank zero. The reference model tracks its own cache, so each step must show or omit the select scans exactly. A second request is also held on the inputs throughout a transaction, so that a sequencer which takes work while busy produces extra scans.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
    localparam int DATA_W = 32;
    localparam int WORD_W = DATA_W + 3;
    localparam int IR_W   = 4;
    localparam int SEL_W  = 3;

    localparam logic [IR_W-1:0] IR_DPREG = 4'b1010;
    localparam logic [IR_W-1:0] IR_APREG = 4'b1011;
    localparam logic [IR_W-1:0] IR_IDENT = 4'b1110;
    localparam logic [IR_W-1:0] IR_ABORT = 4'b1000;

    localparam logic [DATA_W-1:0] BANK_MASK = 32'hFF00_00F0;

    localparam logic [SEL_W-1:0] RS_IDENT  = 3'd0;
    localparam logic [SEL_W-1:0] RS_ABORT  = 3'd1;
    localparam logic [SEL_W-1:0] RS_CTRL   = 3'd2;
    localparam logic [SEL_W-1:0] RS_SELECT = 3'd3;
    localparam logic [SEL_W-1:0] RS_RDBUF  = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL_IR, S_SEL_DR, S_ACC_IR, S_ACC_DR,
        S_RB_IR, S_RB_DR, S_GAP, S_DONE
    } seq_state_t;

    function automatic logic [WORD_W-1:0] acc_word(
        input logic [DATA_W-1:0] data, input logic [1:0] a, input logic rnw);
        return {data, a, rnw};
    endfunction

    function automatic logic [WORD_W-1:0] ir_word(input logic [IR_W-1:0] code);
        return {{(WORD_W-IR_W){1'b0}}, code};
    endfunction
endpackage

// File: rtl/dseq_decode.sv
module dseq_decode
    import dseq_pkg::*;
(
    input  logic             is_ap,
    input  logic             is_write,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [1:0]       ap_a,
    output logic             legal,
    output logic [IR_W-1:0]  ir_code,
    output logic [1:0]       acc_a,
    output logic             ident,
    output logic             need_rb
);
    always_comb begin
        legal   = 1'b1;
        ir_code = IR_DPREG;
        acc_a   = 2'd0;
        ident   = 1'b0;
        need_rb = 1'b0;
        if (is_ap) begin
            ir_code = IR_APREG;
            acc_a   = ap_a;
            need_rb = !is_write;
        end else begin
            unique case (reg_sel)
                RS_IDENT: begin
                    legal   = !is_write;
                    ir_code = IR_IDENT;
                    ident   = 1'b1;
                end
                RS_ABORT: begin
                    legal   = is_write;
                    ir_code = IR_ABORT;
                end
                RS_CTRL: begin
                    acc_a   = 2'd1;
                    need_rb = !is_write;
                end
                RS_SELECT: begin
                    acc_a   = 2'd2;
                    need_rb = !is_write;
                end
                RS_RDBUF: begin
                    legal   = !is_write;
                    acc_a   = 2'd3;
                end
                default: legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dseq_gap.sv
module dseq_gap #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] count,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= count;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dbgacc_seq.sv
module dbgacc_seq
    import dseq_pkg::*;
#(
    parameter int SCAN_GAP  = 7,
    parameter int WRITE_GAP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ap,
    input  logic              req_write,
    input  logic [SEL_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              scan_req,
    output logic              scan_ir,
    output logic [WORD_W-1:0] scan_out,
    input  logic              scan_ack,
    input  logic [WORD_W-1:0] scan_in
);
    localparam int GAP_MAX = SCAN_GAP + WRITE_GAP;
    localparam int GCW     = $clog2(GAP_MAX + 1);
    localparam logic [GCW-1:0] GAP_SHORT = GCW'(SCAN_GAP - 1);
    localparam logic [GCW-1:0] GAP_LONG  = GCW'(GAP_MAX - 1);

    seq_state_t state_q, state_d, after_q, after_d;

    logic              ap_q, wr_q, ident_q, rb_q, err_q;
    logic [IR_W-1:0]   ir_q;
    logic [1:0]        a_q;
    logic [DATA_W-1:0] wdata_q, sel_q, cache_q, rdata_q;

    logic            dec_legal, dec_ident, dec_rb;
    logic [IR_W-1:0] dec_ir;
    logic [1:0]      dec_a;
    logic            gap_load, gap_done;
    logic [GCW-1:0]  gap_val;
    logic            accept;
    logic [DATA_W-1:0] req_sel;

    assign accept  = (state_q == S_IDLE) && req_valid;
    assign req_sel = req_addr & BANK_MASK;

    dseq_decode u_dec (
        .is_ap   (req_ap),
        .is_write(req_write),
        .reg_sel (req_reg),
        .ap_a    (req_addr[3:2]),
        .legal   (dec_legal),
        .ir_code (dec_ir),
        .acc_a   (dec_a),
        .ident   (dec_ident),
        .need_rb (dec_rb)
    );

    dseq_gap #(.CW(GCW)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (gap_load),
        .count  (gap_val),
        .expired(gap_done)
    );

    always_comb begin
        state_d  = state_q;
        after_d  = after_q;
        gap_load = 1'b0;
        gap_val  = GAP_SHORT;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (!dec_legal)                          state_d = S_DONE;
                    else if (req_ap && (req_sel != cache_q)) state_d = S_SEL_IR;
                    else                                     state_d = S_ACC_IR;
                end
            end
            S_SEL_IR: if (scan_ack) state_d = S_SEL_DR;
            S_SEL_DR: begin
                if (scan_ack) begin
                    state_d  = S_GAP;
                    after_d  = S_ACC_IR;
                    gap_load = 1'b1;
                end
            end
            S_ACC_IR: if (scan_ack) state_d = S_ACC_DR;
            S_ACC_DR: begin
                if (scan_ack) begin
                    if (ident_q) begin
                        state_d = S_DONE;
                    end else begin
                        state_d  = S_GAP;
                        gap_load = 1'b1;
                        if (ap_q && wr_q) gap_val = GAP_LONG;
                        if (!rb_q)        after_d = S_DONE;
                        else if (ap_q)    after_d = S_RB_IR;
                        else              after_d = S_RB_DR;
                    end
                end
            end
            S_RB_IR: if (scan_ack) state_d = S_RB_DR;
            S_RB_DR: begin
                if (scan_ack) begin
                    state_d  = S_GAP;
                    after_d  = S_DONE;
                    gap_load = 1'b1;
                end
            end
            S_GAP:  if (gap_done) state_d = after_q;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            after_q <= S_DONE;
            ap_q    <= 1'b0;
            wr_q    <= 1'b0;
            ident_q <= 1'b0;
            rb_q    <= 1'b0;
            err_q   <= 1'b0;
            ir_q    <= '0;
            a_q     <= '0;
            wdata_q <= '0;
            sel_q   <= '0;
            cache_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
            if (accept) begin
                ap_q    <= req_ap;
                wr_q    <= req_write;
                ident_q <= dec_ident;
                rb_q    <= dec_rb;
                err_q   <= !dec_legal;
                ir_q    <= dec_ir;
                a_q     <= dec_a;
                wdata_q <= req_wdata;
                sel_q   <= req_sel;
            end
            if (scan_ack) begin
                unique case (state_q)
                    S_SEL_DR: cache_q <= sel_q;
                    S_ACC_DR: begin
                        if (!ap_q && wr_q && (ir_q == IR_DPREG) && (a_q == 2'd2))
                            cache_q <= wdata_q & BANK_MASK;
                        if (!wr_q && !rb_q)
                            rdata_q <= ident_q ? scan_in[DATA_W-1:0] : scan_in[WORD_W-1:3];
                    end
                    S_RB_DR: rdata_q <= scan_in[WORD_W-1:3];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_DONE);
        err      = done && err_q;
        rdata    = rdata_q;
        scan_req = 1'b0;
        scan_ir  = 1'b0;
        scan_out = '0;
        unique case (state_q)
            S_SEL_IR: begin
                scan_req = 1'b1;
                scan_ir  = 1'b1;
                scan_out = ir_word(IR_DPREG);
            end
            S_SEL_DR: begin
                scan_req = 1'b1;
                scan_out = acc_word(sel_q, 2'd2, 1'b0);
            end
            S_ACC_IR: begin
                scan_req = 1'b1;
                scan_ir  = 1'b1;
                scan_out = ir_word(ir_q);
            end
            S_ACC_DR: begin
                scan_req = 1'b1;
                scan_out = ident_q ? '0 : acc_word(wr_q ? wdata_q : '0, a_q, !wr_q);
            end
            S_RB_IR: begin
                scan_req = 1'b1;
                scan_ir  = 1'b1;
                scan_out = ir_word(IR_DPREG);
            end
            S_RB_DR: begin
                scan_req = 1'b1;
                scan_out = acc_word('0, 2'd3, 1'b1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker
    import dseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              scan_req,
    input logic              scan_ir,
    input logic [WORD_W-1:0] scan_out,
    input logic              scan_ack
);
    p_err_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scan_req && !done));

    p_scan_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && !scan_ack) |=> (scan_req && $stable(scan_ir) && $stable(scan_out)));

    p_ir_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && scan_ir) |-> ((scan_out[WORD_W-1:IR_W] == '0) &&
            ((scan_out[IR_W-1:0] == IR_DPREG) || (scan_out[IR_W-1:0] == IR_APREG) ||
             (scan_out[IR_W-1:0] == IR_IDENT) || (scan_out[IR_W-1:0] == IR_ABORT))));
endmodule

bind dbgacc_seq dseq_checker u_dseq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .scan_req(scan_req),
    .scan_ir (scan_ir),
    .scan_out(scan_out),
    .scan_ack(scan_ack)
);

// File: tb/dbgacc_seq_test.sv
module dbgacc_seq_test;
    localparam int PERIOD = 10;
    localparam int SG  = 7;
    localparam int WG  = 8;
    localparam int LAT = 2;
    localparam int SC  = LAT + 1;
    localparam logic [31:0] MSK = 32'hFF00_00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ap = 1'b0, req_write = 1'b0;
    logic [2:0]  req_reg = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, err, scan_req, scan_ir;
    logic [31:0] rdata;
    logic [34:0] scan_out;
    logic        scan_ack;
    logic [34:0] scan_in;

    int checks = 0, fails = 0;
    int eng_cnt, eng_dr;
    int mdr = 0;
    bit mdl_busy = 0, mon_on = 0, finished = 0;
    logic [31:0] mcache = '0;
    bit          q_ir[$];
    logic [34:0] q_val[$];

    always #(PERIOD/2) clk = ~clk;

    dbgacc_seq #(.SCAN_GAP(SG), .WRITE_GAP(WG)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
        .req_write(req_write), .req_reg(req_reg), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .scan_req(scan_req), .scan_ir(scan_ir), .scan_out(scan_out),
        .scan_ack(scan_ack), .scan_in(scan_in));

    function automatic logic [34:0] resp(input int k);
        return {32'h5EED_0000 + 32'(k) * 32'h0001_0203, 3'b101};
    endfunction

    // behavioural JTAG engine: acknowledges each scan LAT cycles after it appears
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_cnt <= 0; eng_dr <= 0; scan_ack <= 1'b0; scan_in <= '0;
        end else if (scan_ack) begin
            scan_ack <= 1'b0; eng_cnt <= 0;
        end else if (scan_req) begin
            if (eng_cnt == LAT - 1) begin
                scan_ack <= 1'b1;
                if (!scan_ir) begin
                    scan_in <= resp(eng_dr);
                    eng_dr  <= eng_dr + 1;
                end
            end else eng_cnt <= eng_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (mon_on) begin
            chk(busy == mdl_busy, "R10 busy", 64'(busy), 64'(mdl_busy));
            if (scan_ack) begin
                if (q_ir.size() == 0) begin
                    chk(0, "R5 unexpected scan", 64'(scan_out), 64'h0);
                end else begin
                    bit ei; logic [34:0] ev;
                    ei = q_ir.pop_front(); ev = q_val.pop_front();
                    chk(scan_ir == ei, "R2 scan kind", 64'(scan_ir), 64'(ei));
                    chk(scan_out == ev, "R3 scan word", 64'(scan_out), 64'(ev));
                end
            end
        end
    end

    task automatic push(input bit ir, input logic [34:0] v);
        q_ir.push_back(ir); q_val.push_back(v);
        if (!ir) mdr++;
    endtask

    task automatic do_req(input bit ap, input bit wr, input logic [2:0] rs,
                          input logic [31:0] addr, input logic [31:0] wd, input bit noise);
        bit legal; int cyc; int n; logic [31:0] rexp; logic [31:0] rprev; logic [31:0] s;
        legal = 1; cyc = 0; rprev = rdata; rexp = rprev;
        if (!ap) begin
            if ((rs == 3'd0 && wr) || (rs == 3'd4 && wr) || (rs == 3'd1 && !wr) || rs > 3'd4)
                legal = 0;
        end
        if (legal && ap) begin
            s = addr & MSK;
            if (s != mcache) begin
                push(1, 35'b1010); push(0, {s, 2'd2, 1'b0});
                cyc += 2*SC + SG; mcache = s;
            end
            push(1, 35'b1011); push(0, {wr ? wd : 32'h0, addr[3:2], !wr});
            cyc += 2*SC + SG;
            if (wr) cyc += WG;
            else begin
                push(1, 35'b1010); push(0, {32'h0, 2'd3, 1'b1});
                cyc += 2*SC + SG; rexp = resp(mdr-1)[34:3];
            end
        end else if (legal) begin
            unique case (rs)
                3'd0: begin push(1, 35'b1110); push(0, 35'h0); cyc += 2*SC; rexp = resp(mdr-1)[31:0]; end
                3'd1: begin push(1, 35'b1000); push(0, {wd, 2'd0, 1'b0}); cyc += 2*SC + SG; end
                3'd4: begin push(1, 35'b1010); push(0, {32'h0, 2'd3, 1'b1}); cyc += 2*SC + SG; rexp = resp(mdr-1)[34:3]; end
                default: begin
                    push(1, 35'b1010);
                    push(0, {wr ? wd : 32'h0, (rs == 3'd2) ? 2'd1 : 2'd2, !wr});
                    cyc += 2*SC + SG;
                    if (wr) begin
                        if (rs == 3'd3) mcache = wd & MSK;
                    end else begin
                        push(0, {32'h0, 2'd3, 1'b1}); cyc += SC + SG; rexp = resp(mdr-1)[34:3];
                    end
                end
            endcase
        end
        @(negedge clk);
        req_valid = 1; req_ap = ap; req_write = wr; req_reg = rs; req_addr = addr; req_wdata = wd;
        @(posedge clk); #1;
        mdl_busy = 1;
        if (noise) begin
            req_ap = !ap; req_write = !wr; req_reg = 3'd2; req_addr = 32'h7700_00A0; req_wdata = 32'hDEAD_BEEF;
        end else req_valid = 0;
        n = 0;
        forever begin
            @(negedge clk); n++;
            if (done || n > 5000) break;
        end
        chk(n == 1 + cyc, "R9 cycles to done", 64'(n), 64'(1 + cyc));
        chk(err == !legal, "R5 err flag", 64'(err), 64'(!legal));
        chk(rdata == rexp, "R6 R8 R12 rdata", 64'(rdata), 64'(rexp));
        chk(q_ir.size() == 0, "R7 scans left", 64'(q_ir.size()), 64'h0);
        @(posedge clk); #1;
        mdl_busy = 0; req_valid = 0;
        @(negedge clk);
        chk(!done && !busy, "R12 done pulse", 64'(done), 64'h0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs in reset and after release
        chk(!busy && !done && !err && !scan_req, "R1 reset outputs", 64'({busy, done, err, scan_req}), 64'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !scan_req, "R1 after release", 64'({busy, done, scan_req}), 64'h0);
        mon_on = 1;
        // R1: bank-zero access needs no select write after reset
        do_req(1, 0, 3'd0, 32'h0000_0008, 32'h0, 0);
        // R7: bank change forces select write; R8 AP write
        do_req(1, 1, 3'd0, 32'h0100_0004, 32'hCAFE_0001, 0);
        // R7: masked-off bits differ only, no select
        do_req(1, 0, 3'd0, 32'h01FF_FF0C, 32'h0, 0);
        // R7: port nibble change
        do_req(1, 0, 3'd0, 32'h0100_0010, 32'h0, 0);
        // R6: debug-port reads
        do_req(0, 0, 3'd2, 32'h0, 32'h0, 0);
        do_req(0, 0, 3'd3, 32'h0, 32'h0, 0);
        do_req(0, 0, 3'd4, 32'h0, 32'h0, 0);
        do_req(0, 0, 3'd0, 32'h0, 32'h0, 0);
        // R4 R3: debug-port writes, R12 rdata held
        do_req(0, 1, 3'd2, 32'h0, 32'h1234_5678, 0);
        do_req(0, 1, 3'd1, 32'h0, 32'h0000_001E, 0);
        // R7: direct select write reloads cache
        do_req(0, 1, 3'd3, 32'h0, 32'h0000_0000, 0);
        do_req(1, 0, 3'd0, 32'h0000_0004, 32'h0, 0);
        // R5: illegal requests
        do_req(0, 1, 3'd0, 32'h0, 32'h1, 0);
        do_req(0, 1, 3'd4, 32'h0, 32'h1, 0);
        do_req(0, 0, 3'd1, 32'h0, 32'h0, 0);
        do_req(0, 0, 3'd6, 32'h0, 32'h0, 0);
        // R10: conflicting request held while busy is ignored
        do_req(1, 0, 3'd0, 32'h0200_0030, 32'h0, 1);
        do_req(0, 0, 3'd2, 32'h0, 32'h0, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule